// File: doc/BRIEF.md
# Packed Subword Arithmetic Unit

This block performs one lane-parallel integer operation on two packed operands each time a request is presented. A 64-bit source is split into independent lanes of 8, 16 or 32 bits. Carries never cross from one lane into the next. Add and subtract can wrap, saturate as signed values or saturate as unsigned values. A multiplier array forms signed 16×16 products per lane. It can return the upper half or the lower half of each product, or sum adjacent products into 32-bit results.

A request is the `in_valid_i` strobe together with the two sources and a 7-bit opcode. The result is registered and appears one cycle later with `out_valid_o`. Between requests the result register keeps its last value.

The opcode is a packed field set:
- `op[6:5]` selects the operation class.
- `op[4]` selects subtract.
- `op[3:2]` selects the overflow mode.
- `op[1:0]` selects the lane size.

An opcode that makes no sense yields an all-zero result.

Top module: `psimd_unit`

## Requirements
- R1: With `op[6:5]=00`, `op[4]=0` and `op[3:2]=00`, each lane holds the sum of the matching source lanes truncated to the lane width. Lane size is set by `op[1:0]`: 00 gives 8-bit lanes, 01 gives 16-bit lanes and 10 gives 32-bit lanes. No carry passes between lanes.
- R2: With `op[6:5]=00`, `op[4]=1` and `op[3:2]=00`, each lane holds source A minus source B, truncated to the lane width, for 8-, 16- or 32-bit lanes.
- R3: With `op[3:2]=01` (signed saturation) and 8- or 16-bit lanes, a lane result above the largest signed value becomes that value, 0x7F or 0x7FFF. A lane result below the smallest signed value becomes 0x80 or 0x8000.
- R4: With `op[3:2]=10` (unsigned saturation) and 8- or 16-bit lanes, an add that exceeds the lane range gives all ones in that lane. A subtract that would go below zero gives zero in that lane.
- R5: With `op[6:5]=01`, each 16-bit result lane holds bits 31:16 of the signed product of the matching 16-bit source lanes. Bits `op[4:0]` have no effect.
- R6: With `op[6:5]=10`, each 16-bit result lane holds bits 15:0 of the same signed product. Bits `op[4:0]` have no effect.
- R7: With `op[6:5]=11`, result bits 31:0 hold the sum of the products of 16-bit lanes 0 and 1. Result bits 63:32 hold the sum of the products of lanes 2 and 3. Each sum wraps at 32 bits.
- R8: An add/subtract opcode with `op[3:2]=11`, with `op[1:0]=11`, or with a saturating mode on 32-bit lanes produces a result of zero.
- R9: `out_valid_o` is high exactly in the cycle after a cycle in which `in_valid_i` was sampled high. The result for that request is presented with it.
- R10: When `in_valid_i` is low, `result_o` keeps its previous value regardless of the sources and opcode.
- R11: While reset is active, and until reset release has passed the internal two-stage synchronizer, `out_valid_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 7 | Opcode: class [6:5], subtract [4], overflow mode [3:2], lane size [1:0] |
| src_a_i | input | 64 | First packed source |
| src_b_i | input | 64 | Second packed source |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Registered packed result |

## Verification
The bench builds the unit with its defaults, DATA_W of 64 and MUL_W of 16. With these values all three lane sizes, the four-product multiplier array and the two pairwise sums are present together. This brings every opcode class, including the reserved encodings, within reach of a random 7-bit opcode.

Source patterns are drawn partly from per-lane extremes (0x00, 0x7F, 0x80, 0xFF). This makes clamping in both directions and lane-boundary carries frequent rather than rare. The doubled -32768 product that wraps a pair sum is driven directly.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  typedef enum logic [1:0] {
    CL_ADDSUB = 2'b00,
    CL_MULHI  = 2'b01,
    CL_MULLO  = 2'b10,
    CL_MADD   = 2'b11
  } op_class_e;

  typedef enum logic [1:0] {
    MD_WRAP = 2'b00,
    MD_SSAT = 2'b01,
    MD_USAT = 2'b10,
    MD_RSVD = 2'b11
  } ovf_mode_e;

  typedef enum logic [1:0] {
    SZ_8    = 2'b00,
    SZ_16   = 2'b01,
    SZ_32   = 2'b10,
    SZ_RSVD = 2'b11
  } lane_size_e;

  typedef struct packed {
    op_class_e  cls;
    logic       sub;
    ovf_mode_e  mode;
    lane_size_e size;
  } op_t;

  localparam int OP_W      = $bits(op_t);
  localparam int NUM_SIZES = 3;

endpackage

// File: rtl/psimd_lane.sv
module psimd_lane
  import psimd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  ovf_mode_e    mode_i,
  output logic [W-1:0] res_o
);

  logic [W:0] uext;
  logic [W:0] sext;
  logic       s_ovf;

  always_comb begin
    uext  = sub_i ? ({1'b0, a_i} - {1'b0, b_i}) : ({1'b0, a_i} + {1'b0, b_i});
    sext  = sub_i ? ({a_i[W-1], a_i} - {b_i[W-1], b_i})
                  : ({a_i[W-1], a_i} + {b_i[W-1], b_i});
    s_ovf = sext[W] ^ sext[W-1];
    case (mode_i)
      MD_WRAP: res_o = uext[W-1:0];
      MD_SSAT: begin
        if (s_ovf) res_o = sext[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        else       res_o = sext[W-1:0];
      end
      MD_USAT: begin
        if (uext[W]) res_o = sub_i ? {W{1'b0}} : {W{1'b1}};
        else         res_o = uext[W-1:0];
      end
      default: res_o = '0;
    endcase
  end

  // Saturation guards on the lane output
  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i, mode_i, res_o})) begin
      if (mode_i == MD_USAT && !sub_i)
        p_usat_add_r4: assert (res_o >= a_i) else $error("unsigned add fell below source");
      if (mode_i == MD_USAT && sub_i)
        p_usat_sub_r4: assert (res_o <= a_i) else $error("unsigned sub rose above source");
      if (mode_i == MD_SSAT && !sub_i && (a_i[W-1] == b_i[W-1]))
        p_ssat_sign_r3: assert (res_o[W-1] == a_i[W-1]) else $error("signed add flipped sign");
    end
  end

endmodule

// File: rtl/psimd_addsub.sv
module psimd_addsub
  import psimd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  ovf_mode_e         mode_i,
  input  lane_size_e        size_i,
  output logic [DATA_W-1:0] res_o
);

  logic [NUM_SIZES-1:0][DATA_W-1:0] by_size;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW = 8 << g;
    localparam int NL = DATA_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      psimd_lane #(.W(LW)) u_lane (
        .a_i   (a_i[l*LW +: LW]),
        .b_i   (b_i[l*LW +: LW]),
        .sub_i (sub_i),
        .mode_i(mode_i),
        .res_o (by_size[g][l*LW +: LW])
      );
    end
  end

  always_comb begin
    case (size_i)
      SZ_8:    res_o = by_size[0];
      SZ_16:   res_o = by_size[1];
      SZ_32:   res_o = by_size[2];
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/psimd_mul.sv
module psimd_mul #(
  parameter int DATA_W = 64,
  parameter int MUL_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] madd_o
);

  localparam int NP = DATA_W / MUL_W;
  localparam int PW = 2 * MUL_W;
  localparam int NS = NP / 2;

  logic [NP-1:0][PW-1:0] prod;

  for (genvar i = 0; i < NP; i++) begin : g_prod
    assign prod[i] = $signed(a_i[i*MUL_W +: MUL_W]) * $signed(b_i[i*MUL_W +: MUL_W]);
    assign hi_o[i*MUL_W +: MUL_W] = prod[i][PW-1:MUL_W];
    assign lo_o[i*MUL_W +: MUL_W] = prod[i][MUL_W-1:0];
  end

  for (genvar j = 0; j < NS; j++) begin : g_pair
    assign madd_o[j*PW +: PW] = prod[2*j] + prod[2*j+1];
  end

endmodule

// File: rtl/psimd_unit.sv
module psimd_unit
  import psimd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MUL_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o
);

  op_t               op;
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic              legal;
  logic              res_en;
  logic [DATA_W-1:0] addsub_res;
  logic [DATA_W-1:0] mul_hi;
  logic [DATA_W-1:0] mul_lo;
  logic [DATA_W-1:0] mul_madd;
  logic [DATA_W-1:0] res_d, res_q;
  logic              vld_d, vld_q;

  assign op = op_t'(op_i);

  // Reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  psimd_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .sub_i (op.sub),
    .mode_i(op.mode),
    .size_i(op.size),
    .res_o (addsub_res)
  );

  psimd_mul #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_mul (
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .hi_o  (mul_hi),
    .lo_o  (mul_lo),
    .madd_o(mul_madd)
  );

  // Next-state logic
  always_comb begin
    legal = (op.cls != CL_ADDSUB) ||
            ((op.mode != MD_RSVD) && (op.size != SZ_RSVD) &&
             !((op.mode != MD_WRAP) && (op.size == SZ_32)));
    case (op.cls)
      CL_ADDSUB: res_d = legal ? addsub_res : '0;
      CL_MULHI:  res_d = mul_hi;
      CL_MULLO:  res_d = mul_lo;
      default:   res_d = mul_madd;
    endcase
    res_en = in_valid_i;
    vld_d  = in_valid_i;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid_o = vld_q;
  assign result_o    = res_q;

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    in_valid_i |=> out_valid_o) else $error("valid did not follow request");

  p_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !in_valid_i |=> !out_valid_o) else $error("valid without request");

  p_hold_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !in_valid_i |=> $stable(result_o)) else $error("result changed while idle");

  p_illegal_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (in_valid_i && (op_i[6:5] == 2'b00) && ((op_i[3:2] == 2'b11) || (op_i[1:0] == 2'b11)))
    |=> (result_o == '0)) else $error("reserved opcode gave nonzero result");

endmodule

// File: tb/test_psimd_unit.sv
module test_psimd_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [6:0]  op;
  logic [63:0] src_a, src_b;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  psimd_unit i_psimd_unit (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .op_i       (op),
    .src_a_i    (src_a),
    .src_b_i    (src_b),
    .out_valid_o(out_valid),
    .result_o   (result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] ref_model(logic [6:0] o, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    longint w, mask, ua, ub, sa, sb, v, hi, lo;
    longint p [4];
    longint s;
    r = '0;
    if (o[6:5] == 2'b00) begin
      if (o[3:2] == 2'b11 || o[1:0] == 2'b11 || (o[3:2] != 2'b00 && o[1:0] == 2'b10))
        return '0;
      w    = 8 << o[1:0];
      mask = (longint'(1) << w) - 1;
      for (int i = 0; i < 64 / w; i++) begin
        ua = longint'((a >> (i * w)) & 64'(mask));
        ub = longint'((b >> (i * w)) & 64'(mask));
        sa = ua[w-1] ? ua - (longint'(1) << w) : ua;
        sb = ub[w-1] ? ub - (longint'(1) << w) : ub;
        if (o[3:2] == 2'b01) begin
          v  = o[4] ? sa - sb : sa + sb;
          hi = (longint'(1) << (w - 1)) - 1;
          lo = -(longint'(1) << (w - 1));
          if (v > hi) v = hi;
          if (v < lo) v = lo;
        end else begin
          v = o[4] ? ua - ub : ua + ub;
          if (o[3:2] == 2'b10) begin
            if (v < 0)    v = 0;
            if (v > mask) v = mask;
          end
        end
        r = r | ((64'(v) & 64'(mask)) << (i * w));
      end
      return r;
    end
    for (int i = 0; i < 4; i++)
      p[i] = longint'($signed(a[i*16 +: 16])) * longint'($signed(b[i*16 +: 16]));
    for (int i = 0; i < 4; i++) begin
      if (o[6:5] == 2'b01) r[i*16 +: 16] = p[i][31:16];
      else                 r[i*16 +: 16] = p[i][15:0];
    end
    if (o[6:5] == 2'b11) begin
      for (int j = 0; j < 2; j++) begin
        s = p[2*j] + p[2*j+1];
        r[j*32 +: 32] = s[31:0];
      end
    end
    return r;
  endfunction

  function automatic string req_tag(logic [6:0] o);
    case (o[6:5])
      2'b01: return "R5";
      2'b10: return "R6";
      2'b11: return "R7";
      default: begin
        if (o[3:2] == 2'b11 || o[1:0] == 2'b11 || (o[3:2] != 2'b00 && o[1:0] == 2'b10))
          return "R8";
        if (o[3:2] == 2'b01) return "R3";
        if (o[3:2] == 2'b10) return "R4";
        return o[4] ? "R2" : "R1";
      end
    endcase
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [6:0] o, logic [63:0] a, logic [63:0] b, bit idle_check);
    logic [63:0] exp;
    exp = ref_model(o, a, b);
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    op = 7'($urandom); src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
    check64("R9 valid", 64'(out_valid), 64'd1);
    check64(req_tag(o), result, exp);
    if (idle_check) begin
      @(negedge clk);
      check64("R9 idle valid", 64'(out_valid), 64'd0);
      check64("R10 hold", result, exp);
    end
  endtask

  function automatic logic [63:0] pick_data();
    case ($urandom % 4)
      0: return {$urandom, $urandom};
      1: begin
        logic [63:0] d;
        for (int k = 0; k < 8; k++) begin
          case ($urandom % 4)
            0: d[k*8 +: 8] = 8'h00;
            1: d[k*8 +: 8] = 8'h7F;
            2: d[k*8 +: 8] = 8'h80;
            default: d[k*8 +: 8] = 8'hFF;
          endcase
        end
        return d;
      end
      2: return {4{16'($urandom % 3 == 0 ? 16'h8000 : 16'h7FFF)}};
      default: return 64'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    in_valid = 1'b1; src_a = '1; src_b = '1;
    @(negedge clk);
    check64("R11 reset valid", 64'(out_valid), 64'd0);
    check64("R11 reset result", result, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check64("R11 post-release valid", 64'(out_valid), 64'd0);
    check64("R11 post-release result", result, 64'd0);

    // Directed corners
    apply(7'b00_0_00_00, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1); // R1 lane isolation
    apply(7'b00_0_00_10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1); // R1 32-bit lanes
    apply(7'b00_1_00_01, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001, 0); // R2
    apply(7'b00_0_01_00, 64'h7F7F_8080_7F00_8000, 64'h0101_FFFF_0100_FF00, 1); // R3 8-bit
    apply(7'b00_1_01_01, 64'h8000_7FFF_0000_8000, 64'h0001_FFFF_8000_7FFF, 0); // R3 16-bit
    apply(7'b00_0_10_00, 64'hFF80_FF00_0102_7F80, 64'h0180_0100_FFFE_0180, 0); // R4 add
    apply(7'b00_1_10_01, 64'h0000_0005_FFFF_1234, 64'h0001_0005_0000_1235, 0); // R4 sub
    apply(7'b01_0_00_00, 64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFD, 0); // R5
    apply(7'b10_1_11_11, 64'h8000_7FFF_FFFF_0003, 64'h8000_7FFF_0002_FFFD, 0); // R6
    apply(7'b11_0_00_00, 64'h8000_8000_0003_FFFF, 64'h8000_8000_0004_0002, 1); // R7 wrap
    apply(7'b00_0_01_10, 64'h7FFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 1); // R8 sat on 32
    apply(7'b00_0_11_00, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 0); // R8 reserved mode
    apply(7'b00_1_00_11, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 0); // R8 reserved size

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] o;
      o = 7'($urandom);
      if (o[6:5] == 2'b00 && ($urandom % 4 != 0)) begin
        o[3:2] = 2'($urandom % 3);
        o[1:0] = (o[3:2] == 2'b00) ? 2'($urandom % 3) : 2'($urandom % 2);
      end
      apply(o, pick_data(), pick_data(), (n % 8) == 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule